// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

This block is a purely combinational 32-bit adder-subtractor. The operand bits are split into eight slices of four bits. Each slice first forms, for every bit, a generate term and a propagate term. The slice then computes its local carries and sum bits. It also reduces its bits to one generate/propagate pair that summarises the whole slice. A second lookahead stage takes the eight pairs and forms the carry into every slice at the same time, using the same sum-of-products equations. No carry has to wait for a carry from a lower slice.

One mode input selects between addition and subtraction. Subtraction inverts the second operand inside the per-bit terms and forces the initial carry to one, so the same carry network computes the two's-complement difference. Besides the result and carry-out, the block exposes the generate/propagate pair of the full 32-bit word. A wider lookahead tree can use that pair as one of its own leaves.

Top module: `cla_addsub32`

## Requirements
- R1: With `sub_en` = 0, `result` equals the low 32 bits of `opa + opb + cin` and `cout` equals bit 32 of that sum.
- R2: With `sub_en` = 1, `result` equals `opa - opb` modulo 2^32 and `cout` is 1 exactly when `opa >= opb` as unsigned numbers (no borrow).
- R3: While `sub_en` = 1, `cin` has no effect: flipping `cin` leaves `result`, `cout`, `word_gen` and `word_prop` unchanged.
- R4: `word_prop` is 1 exactly when every bit of `opa XOR opb'` is 1, where `opb'` is `opb` in add mode and `~opb` in subtract mode. In that case `word_gen` is 0.
- R5: `word_gen` is 1 exactly when `opa + opb'` with a zero incoming carry produces a carry out of bit 31.
- R6: `cout` always equals `word_gen OR (word_prop AND c0)`, where `c0` is `cin` in add mode and 1 in subtract mode.
- R7: A carry entering the lowest bit travels the full word. All-ones plus zero with `cin` = 1 gives `result` = 0 and `cout` = 1, and a carry out of any slice reaches the next slice's sum bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (subtrahend in subtract mode) |
| cin | input | 1 | Carry into bit 0, add mode only |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| result | output | 32 | Sum or difference |
| cout | output | 1 | Carry out of bit 31 |
| word_gen | output | 1 | Whole-word generate term |
| word_prop | output | 1 | Whole-word propagate term |

## Verification
The block holds no state, so any fault in a slice summary or in a second-stage carry shows at the ports in the same evaluation as the input change that exposes it. The fault appears as wrong result bits starting at the lowest bit of the slice above the bad carry, and usually as a wrong `cout` as well. A fault in the inversion or the forced carry of subtract mode shows up as an off-by-one difference, or as a dependence on `cin` that should not exist. A faulty word-level pair breaks the relation between `cout`, `word_gen` and `word_prop` even when `result` is right. For that reason all four outputs are compared on every vector.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Purpose : shared sizing and the generate/propagate pair type for the
//           two-level lookahead adder-subtractor.
// Assumes : the data width is an exact multiple of the slice width.
package cla_pkg;

    localparam int SLICE_W  = 4;
    localparam int N_SLICES = 8;
    localparam int DATA_W   = SLICE_W * N_SLICES;

    // One summary pair: gen = carry produced inside, prop = carry passes through.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;

endpackage

// File: rtl/cla_pg_slice.sv
// Module cla_pg_slice
// Purpose : forms per-bit generate (AND) and propagate (XOR) terms.
//           In subtract mode the second operand is inverted before
//           the terms are formed.
// Assumes : sub_en is stable while the result is in use (pure combinational).
module cla_pg_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    input  logic         sub_en,
    output logic [W-1:0] bit_gen,
    output logic [W-1:0] bit_prop
);

    logic [W-1:0] b_eff;

    // Conditionally invert the second operand and form the bit terms.
    always_comb begin
        b_eff    = b_bits ^ {W{sub_en}};
        bit_gen  = a_bits & b_eff;
        bit_prop = a_bits ^ b_eff;
    end

    // A bit can never both generate and propagate with the XOR form.
    always_comb begin
        AST_BIT_GP_DISJOINT: assert ((bit_gen & bit_prop) == '0)
            else $error("bit generate and propagate overlap"); // R4
    end

endmodule

// File: rtl/cla_group.sv
// Module cla_group
// Purpose : one first-level lookahead slice. Every local carry is a flat
//           sum of products over the bit terms and the slice carry-in,
//           so no local carry depends on another local carry. Sum bits
//           reuse the propagate terms. The slice also exports its
//           generate/propagate summary to the second level.
// Assumes : grp_cin arrives from the second-level unit.
module cla_group
    import cla_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] bit_gen,
    input  logic [W-1:0] bit_prop,
    input  logic         grp_cin,
    output logic [W-1:0] grp_sum,
    output gp_pair_t     grp_pair
);

    logic [W:0] loc_carry;

    // Flat sum-of-products for every local carry, including the slice carry-out.
    always_comb begin
        loc_carry    = '0;
        loc_carry[0] = grp_cin;
        for (int k = 1; k <= W; k++) begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = bit_gen[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & bit_prop[m];
                end
                acc = acc | term;
            end
            term = grp_cin;
            for (int m = 0; m < k; m++) begin
                term = term & bit_prop[m];
            end
            loc_carry[k] = acc | term;
        end
    end

    // Sum bits reuse the propagate terms.
    always_comb begin
        grp_sum = bit_prop ^ loc_carry[W-1:0];
    end

    // Slice summary pair, formed without the incoming carry.
    always_comb begin
        logic gacc;
        logic gterm;
        gacc = 1'b0;
        for (int j = 0; j < W; j++) begin
            gterm = bit_gen[j];
            for (int m = j + 1; m < W; m++) begin
                gterm = gterm & bit_prop[m];
            end
            gacc = gacc | gterm;
        end
        grp_pair.gen  = gacc;
        grp_pair.prop = &bit_prop;
    end

    // The summary pair must predict the slice's own flat carry-out.
    always_comb begin
        AST_GRP_SUMMARY_MATCH: assert (loc_carry[W] == (grp_pair.gen | (grp_pair.prop & grp_cin)))
            else $error("slice summary disagrees with local carry-out"); // R6
        if (grp_pair.prop) begin
            AST_GRP_PASS_THROUGH: assert (grp_sum == {W{~grp_cin}})
                else $error("propagating slice produced wrong sum"); // R7
        end
    end

endmodule

// File: rtl/cla_level2.sv
// Module cla_level2
// Purpose : second-level lookahead. Applies the same flat sum-of-products
//           to the slice summary pairs, producing the carry into every slice
//           and the carry-out in parallel, plus the whole-word pair.
// Assumes : pairs are ordered with slice 0 at the least significant end.
module cla_level2
    import cla_pkg::*;
#(
    parameter int N = N_SLICES
) (
    input  logic [N-1:0] s_gen,
    input  logic [N-1:0] s_prop,
    input  logic         c0,
    output logic [N:0]   slice_carry,
    output gp_pair_t     word_pair
);

    // Flat carry into each slice from the summary pairs and c0.
    always_comb begin
        slice_carry    = '0;
        slice_carry[0] = c0;
        for (int k = 1; k <= N; k++) begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = s_gen[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & s_prop[m];
                end
                acc = acc | term;
            end
            term = c0;
            for (int m = 0; m < k; m++) begin
                term = term & s_prop[m];
            end
            slice_carry[k] = acc | term;
        end
    end

    // Whole-word generate/propagate pair.
    always_comb begin
        logic gacc;
        logic gterm;
        gacc = 1'b0;
        for (int j = 0; j < N; j++) begin
            gterm = s_gen[j];
            for (int m = j + 1; m < N; m++) begin
                gterm = gterm & s_prop[m];
            end
            gacc = gacc | gterm;
        end
        word_pair.gen  = gacc;
        word_pair.prop = &s_prop;
    end

    // Word pair must be consistent with the carry-out and mutually exclusive.
    always_comb begin
        AST_WORD_COUT_MATCH: assert (slice_carry[N] == (word_pair.gen | (word_pair.prop & c0)))
            else $error("word summary disagrees with carry-out"); // R6
        AST_WORD_GP_EXCL: assert (!(word_pair.gen && word_pair.prop))
            else $error("word generate and propagate both set"); // R4
    end

endmodule

// File: rtl/cla_addsub32.sv
// Module cla_addsub32
// Purpose : top of the two-level lookahead adder-subtractor. Instantiates
//           one bit-term slice and one lookahead slice per group, and one
//           second-level unit that supplies every slice carry.
// Assumes : purely combinational; cin is used only in add mode.
module cla_addsub32
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    input  logic              sub_en,
    output logic [DATA_W-1:0] result,
    output logic              cout,
    output logic              word_gen,
    output logic              word_prop
);

    logic [DATA_W-1:0] bit_gen;
    logic [DATA_W-1:0] bit_prop;
    logic [N_SLICES-1:0] s_gen;
    logic [N_SLICES-1:0] s_prop;
    logic [N_SLICES:0] slice_carry;
    gp_pair_t          word_pair;
    logic              c0;

    // Initial carry: forced to one for subtraction, external carry otherwise.
    always_comb begin
        c0 = sub_en ? 1'b1 : cin;
    end

    for (genvar gi = 0; gi < N_SLICES; gi++) begin : g_slice
        gp_pair_t pair;

        cla_pg_slice #(.W(SLICE_W)) u_pg (
            .a_bits  (opa[gi*SLICE_W +: SLICE_W]),
            .b_bits  (opb[gi*SLICE_W +: SLICE_W]),
            .sub_en  (sub_en),
            .bit_gen (bit_gen[gi*SLICE_W +: SLICE_W]),
            .bit_prop(bit_prop[gi*SLICE_W +: SLICE_W])
        );

        cla_group #(.W(SLICE_W)) u_grp (
            .bit_gen (bit_gen[gi*SLICE_W +: SLICE_W]),
            .bit_prop(bit_prop[gi*SLICE_W +: SLICE_W]),
            .grp_cin (slice_carry[gi]),
            .grp_sum (result[gi*SLICE_W +: SLICE_W]),
            .grp_pair(pair)
        );

        // Unpack the slice summary onto the second-level vectors.
        always_comb begin
            s_gen[gi]  = pair.gen;
            s_prop[gi] = pair.prop;
        end
    end

    cla_level2 #(.N(N_SLICES)) u_l2 (
        .s_gen      (s_gen),
        .s_prop     (s_prop),
        .c0         (c0),
        .slice_carry(slice_carry),
        .word_pair  (word_pair)
    );

    // Drive the word-level outputs.
    always_comb begin
        cout      = slice_carry[N_SLICES];
        word_gen  = word_pair.gen;
        word_prop = word_pair.prop;
    end

    // Port-level relations that follow from the arithmetic.
    always_comb begin
        if (sub_en && (opa == opb)) begin
            AST_SUB_SELF_ZERO: assert (result == '0 && cout)
                else $error("x - x did not give zero with carry"); // R2
        end
        if (!sub_en && (opb == '0) && !cin) begin
            AST_ADD_IDENTITY: assert (result == opa && !cout)
                else $error("x + 0 did not return x"); // R1
        end
        if (sub_en && (opb == '0)) begin
            AST_SUB_ZERO_KEEP: assert (result == opa && cout)
                else $error("x - 0 did not return x with carry"); // R3
        end
    end

endmodule

// File: tb/sim_cla_addsub32.sv
// Bench sim_cla_addsub32
// Scoreboard bench: the driver task applies a vector on a rising edge and
// queues the expected outputs; the monitor pops and compares on the
// following falling edge.
module sim_cla_addsub32;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic [31:0] res;
        logic        co;
        logic        g;
        logic        p;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cin = 1'b0;
    logic        sub_en = 1'b0;
    logic [31:0] result;
    logic        cout;
    logic        word_gen;
    logic        word_prop;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done   = 1'b0;

    cla_addsub32 u0 (
        .opa      (opa),
        .opb      (opb),
        .cin      (cin),
        .sub_en   (sub_en),
        .result   (result),
        .cout     (cout),
        .word_gen (word_gen),
        .word_prop(word_prop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one vector and push its expected outputs.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic sub, input string tag);
        exp_t        e;
        logic [31:0] bb;
        logic        c0;
        logic [32:0] full;
        logic [32:0] nocarry;
        @(posedge clk);
        opa    = a;
        opb    = b;
        cin    = ci;
        sub_en = sub;
        bb      = sub ? ~b : b;
        c0      = sub ? 1'b1 : ci;
        full    = {1'b0, a} + {1'b0, bb} + {32'd0, c0};
        nocarry = {1'b0, a} + {1'b0, bb};
        e.res = full[31:0];
        e.co  = full[32];
        e.g   = nocarry[32];
        e.p   = &(a ^ bb);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare the design's outputs against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (result !== e.res || cout !== e.co || word_gen !== e.g || word_prop !== e.p) begin
                n_fail++;
                $display("FAIL %s: got res=%h co=%b g=%b p=%b, expected res=%h co=%b g=%b p=%b",
                         e.tag, result, cout, word_gen, word_prop, e.res, e.co, e.g, e.p);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle state with all-zero inputs.
        apply(32'h0, 32'h0, 1'b0, 1'b0, "R1 zero");
        apply(32'h1234_5678, 32'h0, 1'b0, 1'b0, "R1 identity");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 all ones");
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R5 top generate");
        // R4: alternating patterns make every bit propagate.
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, "R4 alt prop cin0");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b0, "R4 alt prop cin1");
        // R7: full-length ripple and slice-boundary carries.
        apply(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R7 full chain");
        apply(32'h0000_000F, 32'h1, 1'b0, 1'b0, "R7 slice boundary");
        apply(32'h0FFF_FFFF, 32'h1, 1'b0, 1'b0, "R7 upper boundary");
        // R2: subtraction corners.
        apply(32'h0000_0005, 32'h3, 1'b0, 1'b1, "R2 small diff");
        apply(32'h0, 32'h1, 1'b0, 1'b1, "R2 borrow");
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, "R2 equal");
        apply(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, "R2 wrap");
        // R3: cin must not matter in subtract mode.
        apply(32'h1357_9BDF, 32'h0246_8ACE, 1'b0, 1'b1, "R3 cin0");
        apply(32'h1357_9BDF, 32'h0246_8ACE, 1'b1, 1'b1, "R3 cin1");
        apply(32'h5555_5555, 32'h5555_5555, 1'b1, 1'b1, "R3 prop sub");
        // R6 and R5: random vectors cover the summary relation in both modes.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 5 == 0) rb = ~ra;
            apply(ra, rb, 1'($urandom()), 1'(i % 2), "R6 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule